// File: doc/BRIEF.md
# DTMF Steering Qualifier and Key Code Latch

This block sits behind a dual-tone frequency validator. The validator reports, on every clock, a level flag that says "a valid row/column tone pair is present right now", along with the 2-bit row index and the 2-bit column index of that pair. The flag chatters under speech and noise. This block qualifies it in time. A pair is accepted only after the flag has stayed high for a programmed number of cycles, and it is let go only after the flag has stayed low for a second programmed number of cycles.

On acceptance, the block turns the row/column pair into a 4-bit key code and holds it. It then raises a guard output, which tracks the tone flag while the pair is held. A fixed settling time later, it raises a delayed-steering flag that tells the host a new key is waiting. An inhibit input blocks the four letter keys. A power-down input freezes all detection. An output-enable input gates the code bus: when it is low, the code bus reads as zero and the valid marker is low, which stands in for tri-state pads.

The inputs are level signals sampled every clock, not a stream, so there is no handshake and no back-pressure. The host reads the code whenever it likes, while the delayed-steering flag is high.

Top module: `dtmf_steer_latch`

## Requirements
- R1: A pair is accepted at the clock edge on which the tone flag has been sampled high for `gtp_cycles` consecutive edges (a value of 0 acts as 1). At that edge the code output updates. A burst shorter than this leaves the code and both flags unchanged.
- R2: An accepted pair is released at the edge on which the tone flag has been sampled low for `gta_cycles` consecutive edges. A shorter dropout neither releases the pair nor starts a new acceptance.
- R3: `gt_flag` is high exactly while a pair is held and the tone flag is high. At all other times it is low.
- R4: `std_flag` rises SETTLE clock edges after the edge that updated the code (4 by default). It falls on the edge that releases the pair.
- R5: Rows 0..3 are the 697/770/852/941 Hz tones and columns 0..3 are the 1209/1336/1477/1633 Hz tones. Keys 1..9 (rows 0..2, columns 0..2) give codes 0001..1001. Row 3 gives `*`=1011 (column 0), `0`=1010 (column 1) and `#`=1100 (column 2). Column 3 gives A=1101, B=1110, C=1111 and D=0000 for rows 0..3.
- R6: While `inhibit_ad` is high, a column-3 pair is never accepted and the code keeps its previous value. Other keys are still accepted.
- R7: `code_oe` follows `out_en`. `code_q` shows the latched code when `out_en` is high and reads 0000 when it is low.
- R8: While `power_down` is high, no pair is accepted. One edge after it is seen high, `std_flag` and `gt_flag` are low and any held pair is dropped. The latched code is kept.
- R9: After reset, the latched code is 0000 and `std_flag` and `gt_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| est_in | input | 1 | Tone-pair-present flag from the validator |
| row_idx | input | 2 | Low-group tone index of the present pair |
| col_idx | input | 2 | High-group tone index of the present pair |
| gtp_cycles | input | CW | Tone-present guard time in cycles |
| gta_cycles | input | CW | Tone-absent guard time in cycles |
| inhibit_ad | input | 1 | Blocks acceptance of column-3 keys |
| power_down | input | 1 | Freezes detection and drops held state |
| out_en | input | 1 | Enables the code bus |
| code_q | output | 4 | Latched key code, gated by out_en |
| code_oe | output | 1 | Code bus valid (pad enable model) |
| std_flag | output | 1 | Delayed steering: a new key is registered |
| gt_flag | output | 1 | Guard-time output |

## Verification
The bench builds the block with CW = 8 and SETTLE = 4, and drives guard times of 6 and 5 cycles, plus 1 for the shortest case. These values make each boundary a few cycles wide. The bench can therefore count edges exactly across acceptance, release, a dropout one cycle short of release, and a burst one cycle short of acceptance. The short guard times also let all sixteen keys pass through the scoreboard quickly, along with inhibit and power-down cases taken mid-tone.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_HELD = 1'b1
  } steer_e;

  localparam logic [1:0] LETTER_COL = 2'd3;
  localparam logic [1:0] STAR_ROW   = 2'd3;

  // Map a row/column index pair onto the 4-bit key code.
  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] r4;
    logic [3:0] c4;
    r4 = {2'b00, row};
    c4 = {2'b00, col};
    if (col == LETTER_COL) begin
      // A..C count up from 13, D wraps to zero
      key_code = 4'd13 + r4;
    end else if (row == STAR_ROW) begin
      case (col)
        2'd0:    key_code = 4'd11;
        2'd1:    key_code = 4'd10;
        default: key_code = 4'd12;
      endcase
    end else begin
      key_code = (r4 * 4'd3) + c4 + 4'd1;
    end
  endfunction

endpackage

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer
  import dtmf_steer_pkg::*;
#(
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tone_ok,
  input  logic          tone_raw,
  input  logic [CW-1:0] gtp,
  input  logic [CW-1:0] gta,
  output logic          steered,
  output logic          steer_next,
  output logic          reg_pulse
);

  steer_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_inc;
  logic          acq_hit;
  logic          rel_hit;

  assign steered = (st_q == ST_HELD);

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
    acq_hit = tone_ok && (cnt_inc >= {1'b0, gtp});
    rel_hit = !tone_raw && (cnt_inc >= {1'b0, gta});

    reg_pulse  = 1'b0;
    steer_next = steered;
    cnt_d      = '0;
    if (clear) begin
      steer_next = 1'b0;
    end else if (!steered) begin
      if (acq_hit) begin
        reg_pulse  = 1'b1;
        steer_next = 1'b1;
      end else if (tone_ok) begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end else begin
      if (rel_hit) begin
        steer_next = 1'b0;
      end else if (!tone_raw) begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= steer_next ? ST_HELD : ST_WAIT;
      cnt_q <= cnt_d;
    end
  end

  // R1: entering the held state requires a qualified tone on that edge
  assert_accept_needs_tone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steered) |-> $past(tone_ok));

  // R2: leaving the held state without power-down requires the tone to be absent
  assert_release_needs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(steered) && !$past(clear)) |-> !$past(tone_raw));

endmodule

// File: rtl/dtmf_settle_delay.sv
module dtmf_settle_delay #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic std
);

  localparam int SW = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [SW-1:0] LAST = SW'(SETTLE - 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      std   <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      std   <= 1'b0;
    end else if (!hold) begin
      cnt_q <= '0;
      std   <= 1'b0;
    end else if (!std) begin
      if (cnt_q == LAST) begin
        std <= 1'b1;
      end else begin
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end

  // R4: the flag only rises while the pair is held and no new load is under way
  assert_std_rise_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std) |-> ($past(hold) && !$past(start)));

endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch
  import dtmf_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] row,
  input  logic [1:0] col,
  output logic [3:0] code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= 4'd0;
    end else if (load) begin
      code <= key_code(row, col);
    end
  end

endmodule

// File: rtl/dtmf_steer_latch.sv
module dtmf_steer_latch
  import dtmf_steer_pkg::*;
#(
  parameter int CW     = 22,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          est_in,
  input  logic [1:0]    row_idx,
  input  logic [1:0]    col_idx,
  input  logic [CW-1:0] gtp_cycles,
  input  logic [CW-1:0] gta_cycles,
  input  logic          inhibit_ad,
  input  logic          power_down,
  input  logic          out_en,
  output logic [3:0]    code_q,
  output logic          code_oe,
  output logic          std_flag,
  output logic          gt_flag
);

  localparam int CODE_W = 4;

  logic              tone_ok;
  logic              steered;
  logic              steer_next;
  logic              reg_pulse;
  logic [CODE_W-1:0] code_r;

  // A letter key under inhibit is treated as no tone at all
  assign tone_ok = est_in && !power_down && !(inhibit_ad && (col_idx == LETTER_COL));

  dtmf_guard_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (power_down),
    .tone_ok    (tone_ok),
    .tone_raw   (est_in),
    .gtp        (gtp_cycles),
    .gta        (gta_cycles),
    .steered    (steered),
    .steer_next (steer_next),
    .reg_pulse  (reg_pulse)
  );

  dtmf_code_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reg_pulse),
    .row   (row_idx),
    .col   (col_idx),
    .code  (code_r)
  );

  dtmf_settle_delay #(.SETTLE(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (reg_pulse),
    .hold  (steer_next),
    .std   (std_flag)
  );

  assign gt_flag = steered && est_in && !power_down;
  assign code_oe = out_en;

  for (genvar b = 0; b < CODE_W; b++) begin : g_bus
    assign code_q[b] = out_en & code_r[b];
  end

  // R1: the latched code moves only on the edge a pair is accepted
  assert_code_moves_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_r) |-> $rose(steered));

  // R6: no letter key is accepted while inhibit is high
  assert_inhibit_letters_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(steered) && $past(inhibit_ad)) |-> ($past(col_idx) != LETTER_COL));

  // R8: power-down silences both flags on the next edge
  assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (!std_flag && !gt_flag));

endmodule

// File: tb/tb_dtmf_steer_latch.sv
module tb_dtmf_steer_latch;

  localparam int CW  = 8;
  localparam int GTP = 6;
  localparam int GTA = 5;
  localparam int STL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          est_in = 1'b0;
  logic [1:0]    row_idx = 2'd0;
  logic [1:0]    col_idx = 2'd0;
  logic [CW-1:0] gtp_cycles = CW'(GTP);
  logic [CW-1:0] gta_cycles = CW'(GTA);
  logic          inhibit_ad = 1'b0;
  logic          power_down = 1'b0;
  logic          out_en = 1'b1;
  logic [3:0]    code_q;
  logic          code_oe;
  logic          std_flag;
  logic          gt_flag;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  logic std_prev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtmf_steer_latch #(.CW(CW), .SETTLE(STL)) dut (
    .clk(clk), .rst_n(rst_n), .est_in(est_in), .row_idx(row_idx), .col_idx(col_idx),
    .gtp_cycles(gtp_cycles), .gta_cycles(gta_cycles), .inhibit_ad(inhibit_ad),
    .power_down(power_down), .out_en(out_en), .code_q(code_q), .code_oe(code_oe),
    .std_flag(std_flag), .gt_flag(gt_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R5 table, written independently
  function automatic int tb_expect(input int r, input int c);
    case (r * 4 + c)
      0: return 1;   1: return 2;   2: return 3;   3: return 13;
      4: return 4;   5: return 5;   6: return 6;   7: return 14;
      8: return 7;   9: return 8;  10: return 9;  11: return 15;
      12: return 11; 13: return 10; 14: return 12; 15: return 0;
      default: return -1;
    endcase
  endfunction

  // Scoreboard monitor: each rise of std_flag pops one expected code (R4, R5)
  always @(negedge clk) begin
    if (rst_n && std_flag && !std_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected registration", int'(code_q), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(code_q == 4'(e), "R5 scoreboard code", int'(code_q), e);
      end
    end
    std_prev = std_flag;
  end

  // Drive a tone for n edges, then drop it; push an expectation if it should register
  task automatic tone(input int r, input int c, input int n, input bit expect_reg);
    @(negedge clk);
    if (expect_reg) exp_q.push_back(tb_expect(r, c));
    row_idx = 2'(r); col_idx = 2'(c); est_in = 1'b1;
    repeat (n) @(negedge clk);
    est_in = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(code_q == 4'd0, "R9 code after reset", int'(code_q), 0);
    chk(!std_flag, "R9 std after reset", int'(std_flag), 0);
    chk(!gt_flag, "R9 gt after reset", int'(gt_flag), 0);

    // R1 short burst is discarded
    tone(1, 1, GTP - 1, 1'b0);
    gap(GTA + 3);
    chk(code_q == 4'd0, "R1 short burst keeps code", int'(code_q), 0);
    chk(!std_flag, "R1 short burst no std", int'(std_flag), 0);

    // R1 R3 R4 exact edge timing, key 5 (row 1, col 1)
    @(negedge clk);
    exp_q.push_back(5);
    row_idx = 2'd1; col_idx = 2'd1; est_in = 1'b1;
    for (int i = 1; i <= GTP + STL + 2; i++) begin
      @(negedge clk);
      chk(gt_flag == (i >= GTP), "R3 gt timing", int'(gt_flag), int'(i >= GTP));
      chk(std_flag == (i >= GTP + STL), "R4 std timing", int'(std_flag), int'(i >= GTP + STL));
      if (i == GTP - 1) chk(code_q == 4'd0, "R1 code before accept", int'(code_q), 0);
      if (i == GTP)     chk(code_q == 4'd5, "R1 code at accept", int'(code_q), 5);
    end
    // R2 R3 release timing
    est_in = 1'b0;
    for (int j = 1; j <= GTA + 1; j++) begin
      @(negedge clk);
      chk(!gt_flag, "R3 gt low when tone absent", int'(gt_flag), 0);
      chk(std_flag == (j < GTA), "R2 release timing", int'(std_flag), int'(j < GTA));
    end

    // R2 dropout one cycle short of release, key 8 (row 2, col 1)
    tone(2, 1, GTP + STL + 2, 1'b1);
    for (int j = 1; j <= GTA - 1; j++) begin
      @(negedge clk);
      chk(std_flag, "R2 dropout keeps std", int'(std_flag), 1);
    end
    est_in = 1'b1;
    for (int j = 1; j <= GTP + 3; j++) begin
      @(negedge clk);
      chk(std_flag && gt_flag, "R2 held after dropout", int'(std_flag), 1);
    end
    est_in = 1'b0;
    gap(GTA + 2);
    chk(!std_flag, "R2 released after long gap", int'(std_flag), 0);
    chk(code_q == 4'd8, "R2 code kept after release", int'(code_q), 8);

    // R5 all sixteen keys through the scoreboard
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        tone(r, c, GTP + STL + 2, 1'b1);
        gap(GTA + 2);
      end
    end
    last = tb_expect(3, 3);

    // R6 inhibit blocks letters and keeps the code
    tone(3, 2, GTP + STL + 2, 1'b1);
    gap(GTA + 2);
    last = 12;
    inhibit_ad = 1'b1;
    tone(0, 3, GTP + STL + 4, 1'b0);
    gap(GTA + 2);
    chk(code_q == 4'(last), "R6 letter inhibited code kept", int'(code_q), last);
    tone(0, 1, GTP + STL + 2, 1'b1);
    gap(GTA + 2);
    chk(code_q == 4'd2, "R6 digit accepted under inhibit", int'(code_q), 2);
    inhibit_ad = 1'b0;
    tone(1, 3, GTP + STL + 2, 1'b1);
    gap(GTA + 2);
    chk(code_q == 4'd14, "R6 letter accepted after inhibit", int'(code_q), 14);

    // R7 output enable gating
    out_en = 1'b0;
    @(negedge clk);
    chk(code_q == 4'd0, "R7 bus zero when disabled", int'(code_q), 0);
    chk(!code_oe, "R7 oe low", int'(code_oe), 0);
    out_en = 1'b1;
    @(negedge clk);
    chk(code_q == 4'd14, "R7 bus shows code", int'(code_q), 14);
    chk(code_oe, "R7 oe high", int'(code_oe), 1);

    // R8 power-down blocks acceptance
    power_down = 1'b1;
    tone(0, 0, GTP + STL + 4, 1'b0);
    chk(code_q == 4'd14, "R8 no accept in power-down", int'(code_q), 14);
    chk(!std_flag, "R8 no std in power-down", int'(std_flag), 0);
    power_down = 1'b0;
    gap(GTA + 2);
    // R8 power-down drops a held pair, key 6 (row 1, col 2)
    @(negedge clk);
    exp_q.push_back(6);
    row_idx = 2'd1; col_idx = 2'd2; est_in = 1'b1;
    repeat (GTP + STL + 1) @(negedge clk);
    chk(std_flag, "R8 held before power-down", int'(std_flag), 1);
    power_down = 1'b1;
    @(negedge clk);
    chk(!std_flag, "R8 std dropped", int'(std_flag), 0);
    chk(!gt_flag, "R8 gt dropped", int'(gt_flag), 0);
    chk(code_q == 4'd6, "R8 code kept", int'(code_q), 6);
    est_in = 1'b0;
    @(negedge clk);
    power_down = 1'b0;
    gap(GTA + 2);

    // R1 guard time of one cycle, key 9 (row 2, col 2)
    gtp_cycles = CW'(1);
    @(negedge clk);
    exp_q.push_back(9);
    row_idx = 2'd2; col_idx = 2'd2; est_in = 1'b1;
    @(negedge clk);
    chk(code_q == 4'd9, "R1 single-cycle accept", int'(code_q), 9);
    chk(gt_flag, "R3 gt on single-cycle accept", int'(gt_flag), 1);
    est_in = 1'b0;
    gap(GTA + 3);
    gtp_cycles = CW'(GTP);

    chk(exp_q.size() == 0, "R4 all expected registrations seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule